// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address used by load and store instructions in a 32-bit RISC core. Each request selects one of four address modes and an access size. It supplies the base register value, the R0 index value, the global base register value and a raw displacement field. The block adds a base to either a zero-extended displacement or the index register. For the two short-displacement modes it first scales the displacement by the access size.

The result appears one clock after the request, with a one-cycle valid pulse. Alongside it come a misalignment flag and an illegal-size flag. Instruction decode, the register file, the memory access and any exception handling stay outside the block. The address and the flags hold their last values between results.

Top module: `ldst_eagen`

## Requirements
- R1: With modeSel = 00, the address is baseVal plus dispRaw[3:0], zero-extended and shifted left by 0, 1 or 2 bits for sizeSel 00 (byte), 01 (word) or 10 (longword).
- R2: With modeSel = 01, the address is baseVal plus dispRaw[11:0], zero-extended, with no scaling for any access size.
- R3: With modeSel = 10, the address is baseVal plus indexVal, and dispRaw has no effect on the result.
- R4: With modeSel = 11, the address is gbrVal plus dispRaw[7:0], zero-extended and scaled the same way as in R1.
- R5: Every addition is 32 bits wide and wraps modulo 2^32, and any carry out is dropped.
- R6: Displacement bits above the width that the selected mode uses have no effect on the address. The widths are 4 bits for mode 00, 12 bits for mode 01 and 8 bits for mode 11.
- R7: An inValid high at a rising edge gives outValid high for exactly the following cycle, with effAddr, misalign and sizeErr updated in that cycle. Without inValid, outValid is low and the three result outputs keep their values.
- R8: misalign is 1 for a word result with bit 0 set and for a longword result with either of bits 1:0 set. A byte result never sets misalign.
- R9: sizeSel = 11 is illegal and sets sizeErr to 1. The address is then formed with no scaling, and misalign is 0.
- R10: A synchronous active-high rst clears outValid, effAddr, misalign and sizeErr to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe for the current inputs |
| modeSel | input | 2 | Address mode: 00 short disp, 01 long disp, 10 indexed, 11 GBR-relative |
| sizeSel | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 illegal |
| baseVal | input | 32 | Base register value Rn |
| indexVal | input | 32 | Index register value R0 |
| gbrVal | input | 32 | Global base register value |
| dispRaw | input | 12 | Raw displacement field |
| outValid | output | 1 | One-cycle pulse marking a new result |
| effAddr | output | 32 | Registered effective address |
| misalign | output | 1 | Result is not aligned to the access size |
| sizeErr | output | 1 | Request used the illegal size code |

## Verification
The bench sets the upper displacement bits in every displacement mode. A design that failed to mask them by the mode's width would return a larger address. It also puts junk in the displacement during indexed requests, which would shift the address if the displacement leaked into the sum. Long-displacement requests are sent with the word and longword sizes, so a design that scaled that mode would multiply the displacement. Wrapping sums, odd and half-aligned word and longword results, and the illegal size code on an odd address are also driven. A bad alignment or error path would then set or miss a flag. Back-to-back requests followed by idle cycles expose a valid that is stretched or missing, and a result register that drifts while idle.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int SHORT_DISP_W = 4;
  localparam int GBR_DISP_W   = 8;
  localparam int LONG_DISP_W  = 12;

  typedef enum logic [1:0] {
    MODE_DISP4  = 2'b00,
    MODE_DISP12 = 2'b01,
    MODE_INDEX  = 2'b10,
    MODE_GBR    = 2'b11
  } eagMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } eagSize_e;

  typedef enum logic [1:0] {
    DW_NONE  = 2'b00,
    DW_SHORT = 2'b01,
    DW_MID   = 2'b10,
    DW_FULL  = 2'b11
  } dispWidth_e;

  typedef struct packed {
    logic       load;
    logic       useIndex;
    logic       useGbr;
    dispWidth_e dispWidth;
    logic [1:0] shiftAmt;
    logic       chkWord;
    logic       chkLong;
    logic       sizeBad;
  } eagStrobe_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] modeSel,
  input  logic [1:0] sizeSel,
  output eagStrobe_t strobe,
  output logic       outValid
);
  eagMode_e mode;
  eagSize_e size;
  logic     scaled;

  assign mode = eagMode_e'(modeSel);
  assign size = eagSize_e'(sizeSel);

  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    scaled          = 1'b0;
    case (mode)
      MODE_DISP4: begin
        strobe.dispWidth = DW_SHORT;
        scaled           = 1'b1;
      end
      MODE_DISP12: begin
        strobe.dispWidth = DW_FULL;
      end
      MODE_INDEX: begin
        strobe.dispWidth = DW_NONE;
        strobe.useIndex  = 1'b1;
      end
      default: begin
        strobe.dispWidth = DW_MID;
        strobe.useGbr    = 1'b1;
        scaled           = 1'b1;
      end
    endcase
    case (size)
      SZ_WORD: begin
        strobe.chkWord  = 1'b1;
        strobe.shiftAmt = scaled ? 2'd1 : 2'd0;
      end
      SZ_LONG: begin
        strobe.chkLong  = 1'b1;
        strobe.shiftAmt = scaled ? 2'd2 : 2'd0;
      end
      SZ_BAD:  strobe.sizeBad = 1'b1;
      default: strobe.shiftAmt = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/eag_dp.sv
module eag_dp
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  eagStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] gbrVal,
  input  logic [DISP_W-1:0] dispRaw,
  output logic [ADDR_W-1:0] effAddr,
  output logic              misalign,
  output logic              sizeErr
);
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] dispScaled;
  logic [ADDR_W-1:0] baseOp;
  logic [ADDR_W-1:0] addOp;
  logic [ADDR_W-1:0] sum;
  logic              misNext;

  always_comb begin
    case (strobe.dispWidth)
      DW_SHORT: dispExt = ADDR_W'(dispRaw[SHORT_DISP_W-1:0]);
      DW_MID:   dispExt = ADDR_W'(dispRaw[GBR_DISP_W-1:0]);
      DW_FULL:  dispExt = ADDR_W'(dispRaw[LONG_DISP_W-1:0]);
      default:  dispExt = '0;
    endcase
  end

  assign dispScaled = dispExt << strobe.shiftAmt;
  assign baseOp     = strobe.useGbr ? gbrVal : baseVal;
  assign addOp      = strobe.useIndex ? indexVal : dispScaled;
  assign sum        = baseOp + addOp;
  assign misNext    = (strobe.chkWord & sum[0]) | (strobe.chkLong & (|sum[1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      effAddr  <= '0;
      misalign <= 1'b0;
      sizeErr  <= 1'b0;
    end else if (strobe.load) begin
      effAddr  <= sum;
      misalign <= misNext;
      sizeErr  <= strobe.sizeBad;
    end
  end
endmodule

// File: rtl/ldst_eagen.sv
module ldst_eagen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        sizeSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] gbrVal,
  input  logic [DISP_W-1:0] dispRaw,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              misalign,
  output logic              sizeErr
);
  eagStrobe_t strobe;

  eag_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .sizeSel  (sizeSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  eag_dp #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .gbrVal   (gbrVal),
    .dispRaw  (dispRaw),
    .effAddr  (effAddr),
    .misalign (misalign),
    .sizeErr  (sizeErr)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [1:0]  modeSel,
  input logic [1:0]  sizeSel,
  input logic [31:0] baseVal,
  input logic [31:0] indexVal,
  input logic [31:0] gbrVal,
  input logic [11:0] dispRaw,
  input logic        outValid,
  input logic [31:0] effAddr,
  input logic        misalign,
  input logic        sizeErr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !inValid |=> $stable(effAddr)); // R7
  AST_ERR_NO_MIS: assert property (@(posedge clk) disable iff (rst) sizeErr |-> !misalign); // R9
  AST_INDEX_SUM: assert property (@(posedge clk) disable iff (rst)
    (inValid && modeSel == 2'b10) |=> effAddr == $past(baseVal + indexVal)); // R3
  AST_GBR_BYTE: assert property (@(posedge clk) disable iff (rst)
    (inValid && modeSel == 2'b11 && sizeSel == 2'b00) |=> effAddr == $past(gbrVal + {24'b0, dispRaw[7:0]})); // R4
  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (inValid && sizeSel == 2'b00) |=> !misalign); // R8
  AST_MIS_HAS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (outValid && misalign) |-> (effAddr[1:0] != 2'b00)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!outValid && effAddr == 32'h0 && !misalign && !sizeErr)); // R10
endmodule

bind ldst_eagen eag_chk u_chk (.*);

// File: tb/ldst_eagen_bench.sv
`timescale 1ns/1ps
module ldst_eagen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  modeSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] indexVal = '0;
  logic [31:0] gbrVal = '0;
  logic [11:0] dispRaw = '0;
  logic        outValid;
  logic [31:0] effAddr;
  logic        misalign;
  logic        sizeErr;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;
  logic [33:0] expQ[$];
  string       tagQ[$];
  logic [31:0] lastAddr = '0;

  always #4 clk = ~clk;

  ldst_eagen u_ldst_eagen (.*);

  function automatic logic [33:0] model(input logic [1:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] g, input logic [11:0] d);
    logic [31:0] a;
    logic [31:0] dz;
    int sh;
    logic mis;
    sh = (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
    case (m)
      2'b00: begin dz = {28'b0, d[3:0]}; a = b + (dz << sh); end
      2'b01: a = b + {20'b0, d};
      2'b10: a = b + x;
      default: begin dz = {24'b0, d[7:0]}; a = g + (dz << sh); end
    endcase
    mis = (s == 2'b01 && a[0]) || (s == 2'b10 && a[1:0] != 2'b00);
    return {mis, (s == 2'b11), a};
  endfunction

  task automatic send(input logic [1:0] m, input logic [1:0] s, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] g, input logic [11:0] d, input string tag);
    @(negedge clk);
    modeSel = m; sizeSel = s; baseVal = b; indexVal = x; gbrVal = g; dispRaw = d;
    inValid = 1'b1;
    expQ.push_back(model(m, s, b, x, g, d));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    dispRaw = 12'hABC;
    baseVal = 32'h5555_0000;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected outValid: actual addr=%h expected none", effAddr);
      end else begin
        logic [33:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({misalign, sizeErr, effAddr} !== e) begin
          errors++;
          $display("FAIL %s: actual mis=%b err=%b addr=%h expected mis=%b err=%b addr=%h",
                   t, misalign, sizeErr, effAddr, e[33], e[32], e[31:0]);
        end
        lastAddr = e[31:0];
      end
    end
  end

  task automatic checkIdle(input string tag);
    checks++;
    if (outValid !== 1'b0 || effAddr !== lastAddr) begin
      errors++;
      $display("FAIL %s idle: actual valid=%b addr=%h expected valid=0 addr=%h",
               tag, outValid, effAddr, lastAddr);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          errors++;
          checks++;
          $display("FAIL watchdog expired: actual running expected done");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    checks++; // R10 reset state
    if (outValid !== 1'b0 || effAddr !== 32'h0 || misalign !== 1'b0 || sizeErr !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual valid=%b addr=%h mis=%b err=%b expected all zero",
               outValid, effAddr, misalign, sizeErr);
    end
    rst = 1'b0;
    idle(1);

    // R1 short displacement, each size
    send(2'b00, 2'b00, 32'h0000_1000, 32'h0, 32'h0, 12'h00F, "R1 byte");
    send(2'b00, 2'b01, 32'h0000_1000, 32'h0, 32'h0, 12'h005, "R1 word");
    send(2'b00, 2'b10, 32'h0000_1000, 32'h0, 32'h0, 12'h00F, "R1 long");
    send(2'b00, 2'b00, 32'h0000_2000, 32'h0, 32'h0, 12'hFF3, "R6 short upper bits");
    idle(2);
    checkIdle("R7 after burst");
    // R2 long displacement, never scaled
    send(2'b01, 2'b10, 32'h0000_2000, 32'h0, 32'h0, 12'hFFF, "R2 long size unscaled");
    send(2'b01, 2'b01, 32'h0000_2000, 32'h0, 32'h0, 12'h124, "R2 word size unscaled");
    // R3 indexed
    send(2'b10, 2'b10, 32'h8000_0000, 32'h10, 32'h0, 12'hABC, "R3 indexed disp ignored");
    // R4 GBR-relative
    send(2'b11, 2'b00, 32'h1, 32'h0, 32'h0000_4000, 12'h0FF, "R4 byte");
    send(2'b11, 2'b01, 32'h1, 32'h0, 32'h0000_4000, 12'h080, "R4 word");
    send(2'b11, 2'b10, 32'h1, 32'h0, 32'h0000_4000, 12'h1FF, "R6 gbr upper bits R4 long");
    idle(3);
    checkIdle("R7 hold");
    // R5 wrap
    send(2'b10, 2'b00, 32'hFFFF_FFF0, 32'h20, 32'h0, 12'h0, "R5 indexed wrap");
    send(2'b00, 2'b10, 32'hFFFF_FFFF, 32'h0, 32'h0, 12'h001, "R5 short wrap R8 long mis");
    // R8 alignment
    send(2'b10, 2'b01, 32'h1, 32'h0, 32'h0, 12'h0, "R8 odd word");
    send(2'b10, 2'b10, 32'h2, 32'h0, 32'h0, 12'h0, "R8 half long");
    send(2'b10, 2'b01, 32'h2, 32'h0, 32'h0, 12'h0, "R8 even word");
    send(2'b10, 2'b00, 32'h3, 32'h0, 32'h0, 12'h0, "R8 odd byte");
    // R9 illegal size
    send(2'b00, 2'b11, 32'h0000_1000, 32'h0, 32'h0, 12'h005, "R9 illegal size");
    send(2'b11, 2'b11, 32'h0, 32'h0, 32'h0000_3001, 12'h022, "R9 illegal gbr");
    idle(1);
    send(2'b01, 2'b00, 32'h0000_0100, 32'h0, 32'h0, 12'h001, "R2 byte");
    idle(3);
    checkIdle("R7 single pulse");

    checks++; // R7 every request produced a result
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R7 missing results: actual pending=%0d expected 0", expQ.size());
    end
    // R10 reset clears after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || effAddr !== 32'h0 || misalign !== 1'b0 || sizeErr !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset after use: actual valid=%b addr=%h mis=%b err=%b expected all zero",
               outValid, effAddr, misalign, sizeErr);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule